// File: doc/BRIEF.md
# Edge-Selectable Input Port Interrupt Unit

This block samples twelve external input pins in two groups and turns chosen edges on them into interrupt requests. Group A has eight pins that share a single interrupt source; each of those pins can be masked on its own, and any edge that is not masked sets one shared pending flag. Group B has four pins, and each of them has its own enable bit and its own pending flag. For every pin, a per-pin polarity bit decides whether a rising or a falling edge counts.

Every pin passes through a two-flop synchronizer before edge detection. Software can read the synchronized pin levels. Pending flags stay set until software writes a 1 to them. Each group has a two-bit priority. The block drives one request line per group, and that request carries the group's priority as its level. A priority of zero keeps the group's request silent.

Access is through a simple synchronous byte bus. A write takes effect at the clock edge where `bus_wr` is high. Read data is combinational from `bus_addr`. The reset is asynchronous and active-low, and the block releases it internally two clocks after `rst_n` rises.

Top module: `kport_irq_unit`

## Requirements
- R1: Address 0 returns the synchronized group A pin levels (bit n = pin n, 1 = high). Address 1 returns the group B levels in bits 3:0. A pin change becomes visible two clock edges after it occurs. Writes to addresses 0 and 1 have no effect.
- R2: Address 2 is the group A mask, which resets to 0x00 and reads back. An edge on a group A pin whose mask bit is 0 never sets the group A flag.
- R3: The polarity bits are at address 3 (group A, bit n = pin n) and address 4 (group B, bits 3:0). A value of 1 selects the falling edge and 0 selects the rising edge. All polarity bits reset to 1 and read back.
- R4: A selected edge on any unmasked group A pin sets the shared group A flag, which is bit 0 of address 7. A selected edge on group B pin n sets its own flag, at bit n+1 of address 7. The flag is set on the third clock edge after the pin changes.
- R5: A flag stays 1 until 1 is written to its bit at address 7. Writing 0 has no effect. If an edge sets a flag in the same cycle that a write clears it, the flag stays set.
- R6: Flags are set whether or not the matching enable bit is 1.
- R7: Address 5 holds the priorities: bits 1:0 for group A and bits 3:2 for group B. Both reset to 0. While a group's priority is 0, that group's request is low.
- R8: A group's request is high exactly when one of its set flags has its enable bit at 1 and the group's priority is nonzero. While the request is high, the level output equals the priority; otherwise the level output is 0.
- R9: Address 6 holds the enables: bit 0 for group A and bits 4:1 for group B pins 0 to 3. They reset to 0 and read back. Unused bits at every address read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_a | input | 8 | Group A pins, asynchronous |
| pins_b | input | 4 | Group B pins, asynchronous |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq_a_req | output | 1 | Group A interrupt request |
| irq_a_lvl | output | 2 | Group A request level |
| irq_b_req | output | 1 | Group B interrupt request |
| irq_b_lvl | output | 2 | Group B request level |

## Verification
A polarity bit or a mask bit held in the wrong state shows up as a missing or a spurious flag bit at address 7. It appears three clock edges after the pin toggles, and it shows on the request outputs in the same cycle when that group is enabled with a nonzero priority. A lost collision between a clear and an edge leaves address 7 reading 0 one cycle after the write. A synchronizer stage that is too deep or too shallow moves the level readback by one cycle. Both of these faults are caught by comparing against the bench's cycle model on every clock.

// File: rtl/kport_pkg.sv
package kport_pkg;
  localparam int KP_AW = 3;
  localparam int KP_DW = 8;
  localparam int KP_PW = 2;

  localparam logic [KP_AW-1:0] KP_LVL_A  = 3'd0;
  localparam logic [KP_AW-1:0] KP_LVL_B  = 3'd1;
  localparam logic [KP_AW-1:0] KP_MASK_A = 3'd2;
  localparam logic [KP_AW-1:0] KP_POL_A  = 3'd3;
  localparam logic [KP_AW-1:0] KP_POL_B  = 3'd4;
  localparam logic [KP_AW-1:0] KP_PRIO   = 3'd5;
  localparam logic [KP_AW-1:0] KP_ENAB   = 3'd6;
  localparam logic [KP_AW-1:0] KP_FLAG   = 3'd7;

  typedef logic [KP_PW-1:0] kp_prio_t;
endpackage

// File: rtl/kport_rst_sync.sv
module kport_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sync_n
);
  logic stage0_q, stage1_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage0_q <= 1'b0;
      stage1_q <= 1'b0;
    end else begin
      stage0_q <= 1'b1;
      stage1_q <= stage0_q;
    end
  end

  assign rst_sync_n = stage1_q;
endmodule

// File: rtl/kport_sync_edge.sv
module kport_sync_edge #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  input  logic [W-1:0] fall_sel_i,
  output logic [W-1:0] level_o,
  output logic [W-1:0] event_o
);
  logic [W-1:0] meta_q, cur_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_i;
      cur_q  <= meta_q;
      prev_q <= cur_q;
    end
  end

  assign level_o = cur_q;

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic rise, fall;
    assign rise = cur_q[i] & ~prev_q[i];
    assign fall = ~cur_q[i] & prev_q[i];
    assign event_o[i] = fall_sel_i[i] ? fall : rise;

    AST_EDGE_IS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      event_o[i] |-> (level_o[i] != $past(level_o[i]))); // R3
    AST_EDGE_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
      event_o[i] |-> (level_o[i] == ~fall_sel_i[i])); // R3
  end
endmodule

// File: rtl/kport_req.sv
module kport_req
  import kport_pkg::*;
#(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] flag_i,
  input  logic [W-1:0] en_i,
  input  kp_prio_t     prio_i,
  output logic         req_o,
  output kp_prio_t     lvl_o
);
  logic pending;

  always_comb begin
    pending = |(flag_i & en_i);
    req_o   = pending && (prio_i != '0);
    lvl_o   = req_o ? prio_i : '0;
  end

  AST_REQ_HAS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> (lvl_o != '0)); // R8
  AST_IDLE_LEVEL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !req_o |-> (lvl_o == '0)); // R8
endmodule

// File: rtl/kport_irq_unit.sv
module kport_irq_unit
  import kport_pkg::*;
#(
  parameter int NA = 8,
  parameter int NB = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NA-1:0]    pins_a,
  input  logic [NB-1:0]    pins_b,
  input  logic [KP_AW-1:0] bus_addr,
  input  logic             bus_wr,
  input  logic [KP_DW-1:0] bus_wdata,
  output logic [KP_DW-1:0] bus_rdata,
  output logic             irq_a_req,
  output logic [KP_PW-1:0] irq_a_lvl,
  output logic             irq_b_req,
  output logic [KP_PW-1:0] irq_b_lvl
);
  logic rst_int_n;

  logic [NA-1:0] lvl_a, ev_a;
  logic [NB-1:0] lvl_b, ev_b;

  logic [NA-1:0] mask_q, pol_a_q;
  logic [NB-1:0] pol_b_q, en_b_q, flag_b_q;
  kp_prio_t      prio_a_q, prio_b_q;
  logic          en_a_q, flag_a_q;

  logic          we_mask, we_pol_a, we_pol_b, we_prio, we_en;
  logic [NA-1:0] mask_d, pol_a_d;
  logic [NB-1:0] pol_b_d, en_b_d, clr_b, flag_b_d;
  kp_prio_t      prio_a_d, prio_b_d;
  logic          en_a_d, clr_a, flag_a_d;
  logic [KP_DW-1:0] rdata_c;

  kport_rst_sync u_rst (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_sync_n (rst_int_n)
  );

  kport_sync_edge #(.W(NA)) u_edge_a (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .pin_i      (pins_a),
    .fall_sel_i (pol_a_q),
    .level_o    (lvl_a),
    .event_o    (ev_a)
  );

  kport_sync_edge #(.W(NB)) u_edge_b (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .pin_i      (pins_b),
    .fall_sel_i (pol_b_q),
    .level_o    (lvl_b),
    .event_o    (ev_b)
  );

  // next-state: write decode and flag update
  always_comb begin
    we_mask  = bus_wr && (bus_addr == KP_MASK_A);
    we_pol_a = bus_wr && (bus_addr == KP_POL_A);
    we_pol_b = bus_wr && (bus_addr == KP_POL_B);
    we_prio  = bus_wr && (bus_addr == KP_PRIO);
    we_en    = bus_wr && (bus_addr == KP_ENAB);

    mask_d   = bus_wdata[NA-1:0];
    pol_a_d  = bus_wdata[NA-1:0];
    pol_b_d  = bus_wdata[NB-1:0];
    prio_a_d = bus_wdata[KP_PW-1:0];
    prio_b_d = bus_wdata[2*KP_PW-1:KP_PW];
    en_a_d   = bus_wdata[0];
    en_b_d   = bus_wdata[NB:1];

    clr_a    = bus_wr && (bus_addr == KP_FLAG) && bus_wdata[0];
    clr_b    = (bus_wr && (bus_addr == KP_FLAG)) ? bus_wdata[NB:1] : '0;

    // an edge in the cycle of a clear wins
    flag_a_d = (flag_a_q && !clr_a) || (|(ev_a & mask_q));
    flag_b_d = (flag_b_q & ~clr_b) | ev_b;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mask_q   <= '0;
      pol_a_q  <= '1;
      pol_b_q  <= '1;
      prio_a_q <= '0;
      prio_b_q <= '0;
      en_a_q   <= 1'b0;
      en_b_q   <= '0;
      flag_a_q <= 1'b0;
      flag_b_q <= '0;
    end else begin
      if (we_mask)  mask_q  <= mask_d;
      if (we_pol_a) pol_a_q <= pol_a_d;
      if (we_pol_b) pol_b_q <= pol_b_d;
      if (we_prio) begin
        prio_a_q <= prio_a_d;
        prio_b_q <= prio_b_d;
      end
      if (we_en) begin
        en_a_q <= en_a_d;
        en_b_q <= en_b_d;
      end
      flag_a_q <= flag_a_d;
      flag_b_q <= flag_b_d;
    end
  end

  always_comb begin
    rdata_c = '0;
    case (bus_addr)
      KP_LVL_A:  rdata_c[NA-1:0]      = lvl_a;
      KP_LVL_B:  rdata_c[NB-1:0]      = lvl_b;
      KP_MASK_A: rdata_c[NA-1:0]      = mask_q;
      KP_POL_A:  rdata_c[NA-1:0]      = pol_a_q;
      KP_POL_B:  rdata_c[NB-1:0]      = pol_b_q;
      KP_PRIO:   rdata_c[2*KP_PW-1:0] = {prio_b_q, prio_a_q};
      KP_ENAB:   rdata_c[NB:0]        = {en_b_q, en_a_q};
      KP_FLAG:   rdata_c[NB:0]        = {flag_b_q, flag_a_q};
      default:   rdata_c              = '0;
    endcase
  end

  assign bus_rdata = rdata_c;

  kport_req #(.W(1)) u_req_a (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .flag_i (flag_a_q),
    .en_i   (en_a_q),
    .prio_i (prio_a_q),
    .req_o  (irq_a_req),
    .lvl_o  (irq_a_lvl)
  );

  kport_req #(.W(NB)) u_req_b (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .flag_i (flag_b_q),
    .en_i   (en_b_q),
    .prio_i (prio_b_q),
    .req_o  (irq_b_req),
    .lvl_o  (irq_b_lvl)
  );

  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!flag_a_q && ((ev_a & mask_q) == '0)) |=> !flag_a_q); // R2
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_int_n)
    (flag_a_q && !(bus_wr && bus_addr == KP_FLAG && bus_wdata[0])) |=> flag_a_q); // R5
  AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((ev_b & clr_b) != '0) |=> ((flag_b_q & $past(ev_b & clr_b)) == $past(ev_b & clr_b))); // R5
  AST_ZERO_PRIO_SILENT: assert property (@(posedge clk) disable iff (!rst_int_n)
    (prio_a_q == '0) |-> !irq_a_req); // R7
endmodule

// File: tb/kport_irq_unit_test.sv
module kport_irq_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 100000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] pins_a;
  logic [3:0] pins_b;
  logic [2:0] bus_addr;
  logic       bus_wr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       irq_a_req, irq_b_req;
  logic [1:0] irq_a_lvl, irq_b_lvl;

  int n_chk = 0;
  int n_err = 0;
  bit cmp_en = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  kport_irq_unit uut (
    .clk(clk), .rst_n(rst_n), .pins_a(pins_a), .pins_b(pins_b),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_a_req(irq_a_req), .irq_a_lvl(irq_a_lvl),
    .irq_b_req(irq_b_req), .irq_b_lvl(irq_b_lvl)
  );

  // ---------------- behavioural reference ----------------
  int qa[$];
  int qb[$];
  int m_mask, m_cmpa, m_cmpb, m_pa, m_pb, m_ena, m_enb, m_fa, m_fb;
  int rcnt;

  task automatic m_reset();
    m_mask = 0; m_cmpa = 'hFF; m_cmpb = 'hF; m_pa = 0; m_pb = 0;
    m_ena = 0; m_enb = 0; m_fa = 0; m_fb = 0;
    qa = '{0, 0, 0};
    qb = '{0, 0, 0};
  endtask

  function automatic bit sel_edge(int cur, int prev, int fall);
    return fall ? (prev == 1 && cur == 0) : (prev == 0 && cur == 1);
  endfunction

  task automatic m_step();
    int hit_a = 0;
    int hit_b = 0;
    int clr = 0;
    int wd = int'(bus_wdata);
    for (int i = 0; i < 8; i++)
      if (sel_edge((qa[1] >> i) & 1, (qa[0] >> i) & 1, (m_cmpa >> i) & 1) && ((m_mask >> i) & 1))
        hit_a = 1;
    for (int i = 0; i < 4; i++)
      if (sel_edge((qb[1] >> i) & 1, (qb[0] >> i) & 1, (m_cmpb >> i) & 1))
        hit_b |= (1 << i);
    if (bus_wr && bus_addr == 3'd7) clr = wd;
    m_fa = ((m_fa != 0 && (clr & 1) == 0) || hit_a) ? 1 : 0;
    m_fb = (m_fb & ~(clr >> 1) & 'hF) | hit_b;
    if (bus_wr) begin
      case (int'(bus_addr))
        2: m_mask = wd;
        3: m_cmpa = wd;
        4: m_cmpb = wd & 'hF;
        5: begin m_pa = wd & 3; m_pb = (wd >> 2) & 3; end
        6: begin m_ena = wd & 1; m_enb = (wd >> 1) & 'hF; end
        default: ;
      endcase
    end
    void'(qa.pop_front()); qa.push_back(int'(pins_a));
    void'(qb.pop_front()); qb.push_back(int'(pins_b));
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin m_reset(); rcnt = 0; end
    else if (rcnt < 2) begin m_reset(); rcnt++; end
    else m_step();
  end

  function automatic int m_read(int a);
    case (a)
      0: return qa[1];
      1: return qb[1];
      2: return m_mask;
      3: return m_cmpa;
      4: return m_cmpb;
      5: return (m_pb << 2) | m_pa;
      6: return (m_enb << 1) | m_ena;
      7: return (m_fb << 1) | m_fa;
      default: return 0;
    endcase
  endfunction

  function automatic string addr_tag(int a);
    case (a)
      0, 1: return "R1";
      2: return "R2";
      3, 4: return "R3";
      5: return "R7";
      6: return "R9";
      default: return "R4";
    endcase
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // compare against the reference on every clock
  always @(negedge clk) begin
    if (cmp_en) begin
      int ra, rb;
      ra = (m_fa != 0 && m_ena != 0 && m_pa != 0) ? 1 : 0;
      rb = ((m_fb & m_enb) != 0 && m_pb != 0) ? 1 : 0;
      check(addr_tag(int'(bus_addr)), "model rdata", int'(bus_rdata), m_read(int'(bus_addr)));
      check("R8", "model irq_a_req", int'(irq_a_req), ra);
      check("R8", "model irq_a_lvl", int'(irq_a_lvl), ra ? m_pa : 0);
      check("R8", "model irq_b_req", int'(irq_b_req), rb);
      check("R8", "model irq_b_lvl", int'(irq_b_lvl), rb ? m_pb : 0);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic wr(int a, int d);
    @(posedge clk); #1;
    bus_addr = 3'(a); bus_wdata = 8'(d); bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic set_pins(int a, int b);
    @(posedge clk); #1;
    pins_a = 8'(a); pins_b = 4'(b);
  endtask

  task automatic rd_check(int a, int exp, string tag);
    @(posedge clk); #1;
    bus_addr = 3'(a);
    @(negedge clk);
    check(tag, $sformatf("read addr %0d", a), int'(bus_rdata), exp);
  endtask

  task automatic irq_check(int ra, int la, int rb, int lb, string tag);
    @(negedge clk);
    check(tag, "irq_a_req", int'(irq_a_req), ra);
    check(tag, "irq_a_lvl", int'(irq_a_lvl), la);
    check(tag, "irq_b_req", int'(irq_b_req), rb);
    check(tag, "irq_b_lvl", int'(irq_b_lvl), lb);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog (all requirements): actual=%0d cycles expected=<%0d", WD_CYCLES, WD_CYCLES);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pins_a = '0; pins_b = '0;
    bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    idle(3);
    cmp_en = 1'b1;
    @(posedge clk); #1; rst_n = 1'b1;
    idle(4);

    // reset values
    rd_check(3, 'hFF, "R3");
    rd_check(4, 'h0F, "R3");
    rd_check(2, 'h00, "R2");
    rd_check(5, 'h00, "R7");
    rd_check(6, 'h00, "R9");
    rd_check(7, 'h00, "R4");
    irq_check(0, 0, 0, 0, "R8");

    // R1 level readback and ignored write
    set_pins('hA5, 'h9);
    idle(3);
    rd_check(0, 'hA5, "R1");
    rd_check(1, 'h09, "R1");
    wr(0, 'hFF);
    rd_check(0, 'hA5, "R1");

    // R2 masked edges do nothing
    set_pins('h00, 'h9);
    idle(4);
    rd_check(7, 'h00, "R2");

    // R4 shared flag from unmasked pin, per-pin flags in group B; R6 without enable
    wr(2, 'h04);
    rd_check(2, 'h04, "R2");
    set_pins('h04, 'h9);
    idle(4);
    set_pins('h00, 'h0);
    idle(4);
    rd_check(7, 'h13, "R4");
    irq_check(0, 0, 0, 0, "R6");

    // R5 write-one-to-clear
    wr(7, 'h00);
    rd_check(7, 'h13, "R5");
    wr(7, 'h02);
    rd_check(7, 'h11, "R5");
    wr(7, 'h11);
    rd_check(7, 'h00, "R5");

    // R3 rising-edge selection on group B
    wr(4, 'h00);
    set_pins('h00, 'h2);
    idle(4);
    rd_check(7, 'h04, "R3");

    // R8 request levels
    wr(6, 'h1F);
    wr(5, 'h0E);
    rd_check(6, 'h1F, "R9");
    rd_check(5, 'h0E, "R7");
    irq_check(0, 0, 1, 3, "R8");
    wr(3, 'hFB);
    set_pins('h04, 'h2);
    idle(4);
    irq_check(1, 2, 1, 3, "R8");
    wr(5, 'h0C);
    irq_check(0, 0, 1, 3, "R7");
    wr(6, 'h01);
    irq_check(0, 0, 0, 0, "R8");

    // R5 edge arriving in the clear cycle survives
    wr(7, 'h1F);
    rd_check(7, 'h00, "R5");
    set_pins('h04, 'h3);
    @(posedge clk);
    wr(7, 'h02);
    rd_check(7, 'h02, "R5");

    // mixed traffic against the reference model
    for (int k = 0; k < 3000; k++) begin
      @(posedge clk); #1;
      if (($urandom % 3) == 0) begin
        pins_a = 8'($urandom);
        pins_b = 4'($urandom);
      end
      bus_addr  = 3'($urandom);
      bus_wdata = 8'($urandom);
      bus_wr    = (($urandom % 4) == 0);
    end
    @(posedge clk); #1; bus_wr = 1'b0;

    // reset again mid-run
    rst_n = 1'b0;
    idle(2);
    @(posedge clk); #1; rst_n = 1'b1;
    idle(4);
    rd_check(3, 'hFF, "R3");
    rd_check(7, 'h00, "R4");
    idle(2);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule